// File: doc/BRIEF.md
# Eight-bit Arithmetic Logic Unit with Status Flag Register

This block is the arithmetic and logic datapath of a small accumulator-style processor core. A decoder outside the block presents an operation code and two byte operands; the block returns the low result byte (and a high byte for multiply and divide) in the same cycle, and at the next clock edge it updates an eight-bit status word holding carry, half carry, signed overflow, parity, two free user flags and a two-bit register bank select.

Software may overwrite the status word directly through a write strobe. The parity bit belongs to the hardware: every clock edge it is reloaded from the parity of the accumulator value presented on `acc_val`, whatever else happens. When an operation's flag update and a direct status write land on the same edge, the flags the operation produces win and the written value supplies every other bit.

Top module: `alu8_core`

## Requirements
- R1: The status word has the layout bit 7 carry (CY), bit 6 half carry (AC), bit 5 user flag A, bits 4:3 bank select, bit 2 overflow (OV), bit 1 user flag B, bit 0 parity; a synchronous active-high reset clears it to 00h.
- R2: Codes 0 (add) and 1 (add with carry-in from CY) give `res_lo` = low byte of a+b(+CY) and `res_hi` = 0; with `flag_we` high the next edge loads CY with the carry out of bit 7, AC with the carry out of bit 3, and OV with signed two's-complement overflow.
- R3: Code 2 (subtract with borrow) gives `res_lo` = low byte of a-b-CY; with `flag_we` high CY takes the borrow out of the byte, AC the borrow out of the low nibble, OV signed overflow.
- R4: Codes 3, 4, 5 give a AND b, a OR b, a XOR b; CY, AC and OV keep their values.
- R5: Code 6 rotates a left through carry ({a[6:0],CY}) and code 7 rotates right ({CY,a[7:1]}); CY takes the bit shifted out, AC and OV keep their values.
- R6: Code 8 multiplies a by b with the product's low byte on `res_lo` and high byte on `res_hi`; CY is cleared, OV is set exactly when the product exceeds FFh, AC keeps its value.
- R7: Code 9 divides a by b giving quotient on `res_lo` and remainder on `res_hi`, clearing CY and OV; with b = 0 it gives `res_lo` = FFh, `res_hi` = a and sets OV. AC keeps its value.
- R8: At every clock edge out of reset, bit 0 of the status word becomes the XOR of all bits of `acc_val`, independent of every other input.
- R9: With `psw_we` high the next edge loads bits 7:1 from `psw_wdata`; bit 0 written is ignored. User flags A and B and the bank select bits change only through this write.
- R10: With `flag_we` low an operation changes no flag; codes 10 to 15 give zero on both result bytes and never change a flag.
- R11: When `psw_we` and `flag_we` are both high, the flags that the current operation updates take the operation's values and all other bits 7:1 take the written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select |
| opa | input | 8 | First operand (accumulator side) |
| opb | input | 8 | Second operand |
| flag_we | input | 1 | Let the operation update its flags at the next edge |
| psw_we | input | 1 | Direct write of the status word at the next edge |
| psw_wdata | input | 8 | Value for a direct status write |
| acc_val | input | 8 | Current accumulator contents, source of the parity bit |
| res_lo | output | 8 | Result low byte |
| res_hi | output | 8 | Result high byte (multiply product high, divide remainder) |
| psw | output | 8 | Status word |

## Verification
The two functions that can meet on one edge are the operation's flag update and the software status write, and the parity refresh underlies both. The bench raises `psw_we` together with `flag_we` in directed cases and in a share of random cycles, with write data chosen opposite to the flags the operation produces, and compares the whole status word against a model in which the operation's updated bits override the written ones while untouched bits come from the write and bit 0 from the accumulator parity.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 4;

    localparam int PSW_CY  = 7;
    localparam int PSW_AC  = 6;
    localparam int PSW_UA  = 5;
    localparam int PSW_BK1 = 4;
    localparam int PSW_BK0 = 3;
    localparam int PSW_OV  = 2;
    localparam int PSW_UB  = 1;
    localparam int PSW_P   = 0;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_RLC  = 4'd6,
        OP_RRC  = 4'd7,
        OP_MUL  = 4'd8,
        OP_DIV  = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
        logic wr_cy;
        logic wr_ac;
        logic wr_ov;
    } flag_upd_t;

    typedef struct packed {
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        flag_upd_t     f;
    } alu_res_t;

    function automatic logic odd_ones(input logic [DW-1:0] v);
        return ^v;
    endfunction

    function automatic logic is_logic_op(input logic [OPW-1:0] c);
        return (c == OP_AND) || (c == OP_OR) || (c == OP_XOR);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             cy_in,
    output alu_res_t         r
);
    logic          cin;
    logic          is_sub;
    logic [DW:0]   sum_w;
    logic [DW:0]   dif_w;
    logic [NW:0]   nsum_w;
    logic [NW:0]   ndif_w;

    always_comb begin
        is_sub = (op == OP_SUBB);
        cin    = ((op == OP_ADDC) || is_sub) ? cy_in : 1'b0;
        sum_w  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        dif_w  = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
        nsum_w = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        ndif_w = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};

        r          = '0;
        r.f.wr_cy  = 1'b1;
        r.f.wr_ac  = 1'b1;
        r.f.wr_ov  = 1'b1;
        if (is_sub) begin
            r.lo   = dif_w[DW-1:0];
            r.f.cy = dif_w[DW];
            r.f.ac = ndif_w[NW];
            r.f.ov = (a[DW-1] != b[DW-1]) && (dif_w[DW-1] != a[DW-1]);
        end else begin
            r.lo   = sum_w[DW-1:0];
            r.f.cy = sum_w[DW];
            r.f.ac = nsum_w[NW];
            r.f.ov = (a[DW-1] == b[DW-1]) && (sum_w[DW-1] != a[DW-1]);
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic             cy_in,
    output alu_res_t         r
);
    always_comb begin
        r = '0;
        unique case (op)
            OP_AND: r.lo = a & b;
            OP_OR:  r.lo = a | b;
            OP_XOR: r.lo = a ^ b;
            OP_RLC: begin
                r.lo      = {a[DW-2:0], cy_in};
                r.f.cy    = a[DW-1];
                r.f.wr_cy = 1'b1;
            end
            OP_RRC: begin
                r.lo      = {cy_in, a[DW-1:1]};
                r.f.cy    = a[0];
                r.f.wr_cy = 1'b1;
            end
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
    import alu8_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    output alu_res_t         r
);
    logic [2*DW-1:0] prod;
    logic [DW-1:0]   dvsr;
    logic            by_zero;

    always_comb begin
        prod    = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        by_zero = (b == '0);
        dvsr    = by_zero ? {{(DW-1){1'b0}}, 1'b1} : b;

        r         = '0;
        r.f.cy    = 1'b0;
        r.f.wr_cy = 1'b1;
        r.f.wr_ov = 1'b1;
        if (op == OP_MUL) begin
            r.lo   = prod[DW-1:0];
            r.hi   = prod[2*DW-1:DW];
            r.f.ov = (prod[2*DW-1:DW] != '0);
        end else if (by_zero) begin
            r.lo   = '1;
            r.hi   = a;
            r.f.ov = 1'b1;
        end else begin
            r.lo   = a / dvsr;
            r.hi   = a % dvsr;
            r.f.ov = 1'b0;
        end
    end
endmodule

// File: rtl/alu8_psw.sv
module alu8_psw
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_we,
    input  flag_upd_t        upd,
    input  logic             psw_we,
    input  logic [DW-1:0]    psw_wdata,
    input  logic [DW-1:0]    acc_val,
    output logic [DW-1:0]    psw_q
);
    logic [DW-1:0] psw_d;

    always_comb begin
        psw_d = psw_q;
        if (psw_we) begin
            psw_d = psw_wdata;
        end
        if (flag_we) begin
            if (upd.wr_cy) psw_d[PSW_CY] = upd.cy;
            if (upd.wr_ac) psw_d[PSW_AC] = upd.ac;
            if (upd.wr_ov) psw_d[PSW_OV] = upd.ov;
        end
        psw_d[PSW_P] = odd_ones(acc_val);
    end

    always_ff @(posedge clk) begin
        if (rst) psw_q <= '0;
        else     psw_q <= psw_d;
    end

    // R8
    parity_track_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (psw_q[PSW_P] == (^$past(acc_val))));

    // R9
    user_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(psw_we)) |->
            (psw_q[PSW_UA] == $past(psw_q[PSW_UA])) &&
            (psw_q[PSW_UB] == $past(psw_q[PSW_UB])) &&
            (psw_q[PSW_BK1] == $past(psw_q[PSW_BK1])) &&
            (psw_q[PSW_BK0] == $past(psw_q[PSW_BK0])));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPW-1:0]   op_code,
    input  logic [DW-1:0]    opa,
    input  logic [DW-1:0]    opb,
    input  logic             flag_we,
    input  logic             psw_we,
    input  logic [DW-1:0]    psw_wdata,
    input  logic [DW-1:0]    acc_val,
    output logic [DW-1:0]    res_lo,
    output logic [DW-1:0]    res_hi,
    output logic [DW-1:0]    psw
);
    alu_op_e  op;
    alu_res_t r_arith;
    alu_res_t r_logic;
    alu_res_t r_md;
    alu_res_t r_sel;

    assign op = alu_op_e'(op_code);

    alu8_arith u_arith (
        .op    (op),
        .a     (opa),
        .b     (opb),
        .cy_in (psw[PSW_CY]),
        .r     (r_arith)
    );

    alu8_logic u_logic (
        .op    (op),
        .a     (opa),
        .b     (opb),
        .cy_in (psw[PSW_CY]),
        .r     (r_logic)
    );

    alu8_muldiv u_md (
        .op (op),
        .a  (opa),
        .b  (opb),
        .r  (r_md)
    );

    always_comb begin
        case (op_code)
            OP_ADD, OP_ADDC, OP_SUBB:               r_sel = r_arith;
            OP_AND, OP_OR, OP_XOR, OP_RLC, OP_RRC:  r_sel = r_logic;
            OP_MUL, OP_DIV:                         r_sel = r_md;
            default:                                r_sel = '0;
        endcase
    end

    assign res_lo = r_sel.lo;
    assign res_hi = r_sel.hi;

    alu8_psw u_psw (
        .clk       (clk),
        .rst       (rst),
        .flag_we   (flag_we),
        .upd       (r_sel.f),
        .psw_we    (psw_we),
        .psw_wdata (psw_wdata),
        .acc_val   (acc_val),
        .psw_q     (psw)
    );

    // R6
    mul_cy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_code == OP_MUL) |=> !psw[PSW_CY]);

    // R6
    mul_ov_range_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_code == OP_MUL) |=> (psw[PSW_OV] == ($past(res_hi) != '0)));

    // R7
    div_zero_ov_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_code == OP_DIV && opb == '0) |=> (psw[PSW_OV] && !psw[PSW_CY]));

    // R4
    logic_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !psw_we && is_logic_op(op_code)) |=>
            ($stable(psw[PSW_CY]) && $stable(psw[PSW_AC]) && $stable(psw[PSW_OV])));

    // R10
    no_flag_we_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_we && !psw_we) |=>
            ($stable(psw[PSW_CY]) && $stable(psw[PSW_AC]) && $stable(psw[PSW_OV])));
endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_code = '0;
    logic [7:0] opa = '0, opb = '0;
    logic       flag_we = 1'b0, psw_we = 1'b0;
    logic [7:0] psw_wdata = '0, acc_val = '0;
    logic [7:0] res_lo, res_hi, psw;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    logic [7:0] exp_psw = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_core i_alu8_core (
        .clk(clk), .rst(rst), .op_code(op_code), .opa(opa), .opb(opb),
        .flag_we(flag_we), .psw_we(psw_we), .psw_wdata(psw_wdata),
        .acc_val(acc_val), .res_lo(res_lo), .res_hi(res_hi), .psw(psw)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] o, input logic fw, input logic pw);
        if (fw && pw) return "R11";
        if (!fw) return "R10";
        case (o)
            4'd0, 4'd1: return "R2";
            4'd2:       return "R3";
            4'd3, 4'd4, 4'd5: return "R4";
            4'd6, 4'd7: return "R5";
            4'd8:       return "R6";
            4'd9:       return "R7";
            default:    return "R10";
        endcase
    endfunction

    // Independent model of the requirements.
    task automatic model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] p, input logic fw, input logic pw,
                         input logic [7:0] wd, input logic [7:0] acc,
                         output logic [7:0] lo, output logic [7:0] hi,
                         output logic [7:0] np);
        int s, cin;
        logic cy, ac, ov, wc, wa, wo;
        cy = 1'b0; ac = 1'b0; ov = 1'b0; wc = 1'b0; wa = 1'b0; wo = 1'b0;
        lo = 8'h00; hi = 8'h00;
        cin = (o == 4'd1 || o == 4'd2) ? int'(p[7]) : 0;
        case (o)
            4'd0, 4'd1: begin
                s  = int'(a) + int'(b) + cin;
                lo = s[7:0];
                cy = (s > 255);
                ac = ((int'(a[3:0]) + int'(b[3:0]) + cin) > 15);
                ov = (a[7] == b[7]) && (lo[7] != a[7]);
                wc = 1; wa = 1; wo = 1;
            end
            4'd2: begin
                s  = int'(a) - int'(b) - cin;
                lo = s[7:0];
                cy = (int'(a) < int'(b) + cin);
                ac = (int'(a[3:0]) < int'(b[3:0]) + cin);
                ov = (a[7] != b[7]) && (lo[7] != a[7]);
                wc = 1; wa = 1; wo = 1;
            end
            4'd3: lo = a & b;
            4'd4: lo = a | b;
            4'd5: lo = a ^ b;
            4'd6: begin lo = {a[6:0], p[7]}; cy = a[7]; wc = 1; end
            4'd7: begin lo = {p[7], a[7:1]}; cy = a[0]; wc = 1; end
            4'd8: begin
                s  = int'(a) * int'(b);
                lo = s[7:0]; hi = s[15:8];
                cy = 0; ov = (s > 255); wc = 1; wo = 1;
            end
            4'd9: begin
                if (b == 8'h00) begin lo = 8'hFF; hi = a; ov = 1; end
                else begin lo = a / b; hi = a % b; ov = 0; end
                cy = 0; wc = 1; wo = 1;
            end
            default: ;
        endcase
        np = p;
        if (pw) np[7:1] = wd[7:1];
        if (fw) begin
            if (wc) np[7] = cy;
            if (wa) np[6] = ac;
            if (wo) np[2] = ov;
        end
        np[0] = ^acc;
    endtask

    task automatic run_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic fw, input logic pw, input logic [7:0] wd,
                          input logic [7:0] acc);
        logic [7:0] elo, ehi, np;
        string t;
        @(negedge clk);
        op_code = o; opa = a; opb = b; flag_we = fw; psw_we = pw;
        psw_wdata = wd; acc_val = acc;
        model(o, a, b, exp_psw, fw, pw, wd, acc, elo, ehi, np);
        t = tag_of(o, fw, pw);
        #1;
        chk(t, "res_lo", res_lo, elo);
        chk(t, "res_hi", res_hi, ehi);
        @(posedge clk);
        #1;
        chk(t, "CY/AC/OV", psw & 8'hC4, np & 8'hC4);
        chk("R9", "user/bank bits", psw & 8'h3A, np & 8'h3A);
        chk("R8", "parity", {7'd0, psw[0]}, {7'd0, np[0]});
        exp_psw = np;
    endtask

    function automatic logic [7:0] pick_val();
        case ($urandom % 6)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h80;
            3: return 8'h7F;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd2024));
        acc_val = 8'h5B;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "psw after reset", psw, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        exp_psw = 8'h00;

        // R2: 7 + 10, then carry and half carry out, then signed overflow
        run_op(4'd0, 8'h07, 8'h0A, 1, 0, 8'h00, 8'h11);
        run_op(4'd0, 8'hFF, 8'h01, 1, 0, 8'h00, 8'h00);
        run_op(4'd1, 8'h10, 8'h20, 1, 0, 8'h00, 8'h01);
        run_op(4'd0, 8'h7F, 8'h01, 1, 0, 8'h00, 8'h80);
        // R3: borrow from zero
        run_op(4'd2, 8'h00, 8'h01, 1, 0, 8'h00, 8'hFF);
        run_op(4'd2, 8'h80, 8'h01, 1, 0, 8'h00, 8'h03);
        // R5: rotations through carry
        run_op(4'd6, 8'h81, 8'h00, 1, 0, 8'h00, 8'h00);
        run_op(4'd7, 8'h01, 8'h00, 1, 0, 8'h00, 8'h00);
        // R4: logic keeps flags
        run_op(4'd5, 8'hF0, 8'h3C, 1, 0, 8'h00, 8'h07);
        // R6: largest product
        run_op(4'd8, 8'hFF, 8'hFF, 1, 0, 8'h00, 8'h00);
        run_op(4'd8, 8'h0F, 8'h11, 1, 0, 8'h00, 8'h00);
        // R7: divide by zero and normal divide
        run_op(4'd9, 8'h2A, 8'h00, 1, 0, 8'h00, 8'h00);
        run_op(4'd9, 8'hC8, 8'h07, 1, 0, 8'h00, 8'h00);
        // R9: direct write of user and bank bits, bit 0 ignored
        run_op(4'd3, 8'h00, 8'h00, 0, 1, 8'h3B, 8'h00);
        // R10: flag_we low, then undefined codes
        run_op(4'd0, 8'hFF, 8'hFF, 0, 0, 8'h00, 8'h01);
        run_op(4'd12, 8'h55, 8'hAA, 1, 0, 8'h00, 8'h03);
        // R11: write and multiply on the same edge
        run_op(4'd8, 8'h02, 8'h03, 1, 1, 8'hFF, 8'h00);
        run_op(4'd0, 8'hFF, 8'h01, 1, 1, 8'h00, 8'h00);

        for (int i = 0; i < 800; i++) begin
            logic [3:0] o;
            o = ($urandom % 8 == 0) ? 4'($urandom_range(10, 15)) : 4'($urandom_range(0, 9));
            run_op(o, pick_val(), pick_val(), ($urandom % 4) != 0,
                   ($urandom % 5) == 0, 8'($urandom), 8'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule